// File: doc/BRIEF.md
# Mailbox Completion Status and Interrupt Enable Registers

This block holds the completion flags and the interrupt enables of a 32-mailbox message controller. The message engine sends a one-cycle pulse on a per-mailbox line when a transmit or receive on that mailbox finishes. The block latches each pulse into a sticky flag, and software clears a flag by writing 1 to it. A second register holds one enable per flag. Whenever a set flag meets a set enable, a single registered interrupt line goes high.

A mode input selects how the low byte of the status register is used. In mailbox mode every bit follows its mailbox. In receive-queue mode, bits 7, 6 and 5 latch the queue overflow, queue warning and frame-available pulses. Bits 4 to 1 are reserved and stay 0 in that mode. Bit 0 is still set by completion line 0. Every change of the mode input wipes status bits 7 to 1.

Both registers sit on a plain 32-bit register port with an address, a write strobe, per-byte enables, write data and combinational read data. Only full-word writes, with all four byte enables set, take effect.

Top module: `mbx_stat_irq`

## Requirements
- R1: After reset the status register reads 0x0000_0000, the enable register reads 0x0000_0000 and irq_o is 0.
- R2: The enable register at offset 0x34 is read/write on all 32 bits. The status register is read at offset 0x30. A read of any other offset returns 0.
- R3: A pulse on mbx_done_i[x] sets status bit x. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: If a set pulse and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R5: A write whose byte enables wr_be_i are not all ones (4'hF) changes neither register.
- R6: With fifo_mode_i = 1, status bits 7, 6 and 5 are set by fifo_ovf_i, fifo_warn_i and fifo_avail_i respectively, and mbx_done_i[7:1] has no effect. Bits 0 and 31:8 still follow their mailbox lines.
- R7: With fifo_mode_i = 1, status bits 4 to 1 read as 0.
- R8: In the cycle after fifo_mode_i changes value, status bits 7 to 1 read 0. Any set pulse to those bits in the changing cycle is dropped. Bit 0, bits 31:8 and the enable register are not affected.
- R9: With fifo_mode_i = 0, the three queue event inputs have no effect on the status register.
- R10: irq_o equals the OR-reduction of (status AND enable) as it stood one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_be_i | input | 4 | Byte enables; only 4'hF writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| fifo_mode_i | input | 1 | 1 selects receive-queue meaning of the low status byte |
| mbx_done_i | input | 32 | Per-mailbox completion pulses |
| fifo_avail_i | input | 1 | Queue frame-available pulse |
| fifo_warn_i | input | 1 | Queue warning pulse |
| fifo_ovf_i | input | 1 | Queue overflow pulse |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench drives inputs just after a falling edge. Register contents change at the next rising edge and can be read on rdata_o from the following falling edge onward. irq_o trails the status and enable contents by one more edge, so the bench keeps a separate model interrupt bit. That bit is updated at each edge from the model state as it stood before that edge. Every check is sampled one nanosecond after the inputs are driven, which is mid-cycle and well away from any edge.

// File: rtl/mbx_regs_pkg.sv
package mbx_regs_pkg;
  localparam int BUS_W     = 32;
  localparam int BE_W      = BUS_W / 8;
  localparam int Q_AVL_BIT = 5;
  localparam int Q_WRN_BIT = 6;
  localparam int Q_OVF_BIT = 7;
  localparam int RSV_LO    = 1;
  localparam int RSV_HI    = 4;
  localparam int WIPE_LO   = 1;
  localparam int WIPE_HI   = 7;

  typedef struct packed {
    logic ovf;
    logic wrn;
    logic avl;
  } q_evt_t;
endpackage

// File: rtl/mbx_set_route.sv
module mbx_set_route
  import mbx_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              q_mode_i,
  input  logic [DATA_W-1:0] done_i,
  input  q_evt_t            q_evt_i,
  output logic [DATA_W-1:0] set_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == Q_AVL_BIT) begin : g_avl
      assign set_o[b] = q_mode_i ? q_evt_i.avl : done_i[b];
    end else if (b == Q_WRN_BIT) begin : g_wrn
      assign set_o[b] = q_mode_i ? q_evt_i.wrn : done_i[b];
    end else if (b == Q_OVF_BIT) begin : g_ovf
      assign set_o[b] = q_mode_i ? q_evt_i.ovf : done_i[b];
    end else if (b >= RSV_LO && b <= RSV_HI) begin : g_rsv
      assign set_o[b] = ~q_mode_i & done_i[b];
    end else begin : g_mbx
      assign set_o[b] = done_i[b];
    end
  end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank
  import mbx_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              wipe_i,
  output logic [DATA_W-1:0] flag_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_flag
    logic wipe_b;
    if (b >= WIPE_LO && b <= WIPE_HI) begin : g_w
      assign wipe_b = wipe_i;
    end else begin : g_nw
      assign wipe_b = 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_o[b] <= 1'b0;
      else if (wipe_b) flag_o[b] <= 1'b0;
      else             flag_o[b] <= set_i[b] | (flag_o[b] & ~clr_i[b]); // set beats clear
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] flag_i,
  input  logic [DATA_W-1:0] en_i,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flag_i & en_i);
  end
endmodule

// File: rtl/mbx_stat_irq.sv
module mbx_stat_irq
  import mbx_regs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFF = 8'h30,
  parameter logic [ADDR_W-1:0] IEN_OFF  = 8'h34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              fifo_mode_i,
  input  logic [BUS_W-1:0]  mbx_done_i,
  input  logic              fifo_avail_i,
  input  logic              fifo_warn_i,
  input  logic              fifo_ovf_i,
  output logic              irq_o
);
  logic             word_wr;
  logic             stat_wr;
  logic             ien_wr;
  logic             mode_q;
  logic             mode_chg;
  logic [BUS_W-1:0] stat_q;
  logic [BUS_W-1:0] ien_q;
  logic [BUS_W-1:0] set_vec;
  logic [BUS_W-1:0] clr_vec;
  q_evt_t           q_evt;

  assign word_wr  = wr_en_i & (&wr_be_i);
  assign stat_wr  = word_wr & (addr_i == STAT_OFF);
  assign ien_wr   = word_wr & (addr_i == IEN_OFF);
  assign clr_vec  = stat_wr ? wdata_i : '0;
  assign mode_chg = fifo_mode_i ^ mode_q;
  assign q_evt    = '{ovf: fifo_ovf_i, wrn: fifo_warn_i, avl: fifo_avail_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ien_q  <= '0;
    end else begin
      mode_q <= fifo_mode_i;
      if (ien_wr) ien_q <= wdata_i;
    end
  end

  mbx_set_route #(.DATA_W(BUS_W)) u_route (
    .q_mode_i (fifo_mode_i),
    .done_i   (mbx_done_i),
    .q_evt_i  (q_evt),
    .set_o    (set_vec)
  );

  mbx_flag_bank #(.DATA_W(BUS_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .wipe_i (mode_chg),
    .flag_o (stat_q)
  );

  mbx_irq_gen #(.DATA_W(BUS_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (stat_q),
    .en_i   (ien_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    if (addr_i == STAT_OFF)     rdata_o = stat_q;
    else if (addr_i == IEN_OFF) rdata_o = ien_q;
    else                        rdata_o = '0;
  end
endmodule

// File: rtl/mbx_stat_irq_chk.sv
module mbx_stat_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [3:0]  wr_be_i,
  input logic        fifo_mode_i,
  input logic        mode_q,
  input logic [31:0] mbx_done_i,
  input logic [31:0] stat_q,
  input logic [31:0] ien_q,
  input logic        irq_o
);
  // R10
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(stat_q & ien_q)));

  // R5
  narrow_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_be_i != 4'hF) |=> $stable(ien_q));

  // R4
  high_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbx_done_i[31] |=> stat_q[31]);

  // R8
  mode_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i != mode_q) |=> stat_q[7:1] == 7'd0);

  // R7
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> stat_q[4:1] == 4'd0);
endmodule

bind mbx_stat_irq mbx_stat_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_be_i     (wr_be_i),
  .fifo_mode_i (fifo_mode_i),
  .mode_q      (mode_q),
  .mbx_done_i  (mbx_done_i),
  .stat_q      (stat_q),
  .ien_q       (ien_q),
  .irq_o       (irq_o)
);

// File: tb/mbx_stat_irq_tb_top.sv
`timescale 1ns/1ps
module mbx_stat_irq_tb_top;
  localparam logic [7:0] STAT = 8'h30;
  localparam logic [7:0] IEN  = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        mode = 1'b0;
  logic [31:0] done = '0;
  logic        av = 1'b0, wn = 1'b0, ov = 1'b0;
  logic        irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] stat_m = '0, ien_m = '0;
  logic        mode_m = 1'b0, irq_m = 1'b0;

  always #10 clk = ~clk;

  mbx_stat_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_be_i(be),
    .wdata_i(wd), .rdata_o(rdata), .fifo_mode_i(mode), .mbx_done_i(done),
    .fifo_avail_i(av), .fifo_warn_i(wn), .fifo_ovf_i(ov), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] rd_model(input logic [7:0] a);
    if (a == STAT) return stat_m;
    if (a == IEN)  return ien_m;
    return 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive at negedge, check mid-cycle, advance model at posedge
  task automatic step(input logic [7:0] a, input logic w, input logic [3:0] b,
                      input logic [31:0] d, input logic m, input logic [31:0] dn,
                      input logic e_av, input logic e_wn, input logic e_ov,
                      input string tag);
    logic [31:0] set_v, clr_v, ns;
    addr = a; we = w; be = b; wd = d; mode = m; done = dn;
    av = e_av; wn = e_wn; ov = e_ov;
    #1;
    chk(rdata, rd_model(a), tag);
    chk({31'd0, irq}, {31'd0, irq_m}, "R10");
    set_v = dn;
    if (m) begin
      set_v[4:1] = 4'd0;
      set_v[7:5] = {e_ov, e_wn, e_av};
    end
    clr_v = (w && b == 4'hF && a == STAT) ? d : 32'h0;
    ns = set_v | (stat_m & ~clr_v);
    if (m != mode_m) ns[7:1] = 7'd0;
    @(posedge clk);
    irq_m  = |(stat_m & ien_m);
    stat_m = ns;
    if (w && b == 4'hF && a == IEN) ien_m = d;
    mode_m = m;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic m, input string tag);
    step(a, 1'b0, 4'hF, 32'h0, m, 32'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    addr = STAT; #1; chk(rdata, 32'h0, "R1 status");
    addr = IEN;  #1; chk(rdata, 32'h0, "R1 enable");
    chk({31'd0, irq}, 32'h0, "R1 irq");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 enable rw, other offset reads 0
    step(IEN, 1'b1, 4'hF, 32'hA5C3_0F81, 1'b0, 0, 0, 0, 0, "R2");
    rd(IEN, 1'b0, "R2 enable readback");
    step(8'h38, 1'b1, 4'hF, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, 0, "R2");
    rd(8'h38, 1'b0, "R2 unmapped reads 0");
    // R5 narrow write ignored
    step(IEN, 1'b1, 4'h3, 32'h0, 1'b0, 0, 0, 0, 0, "R5");
    rd(IEN, 1'b0, "R5 narrow write ignored");
    step(STAT, 1'b0, 4'hF, 0, 1'b0, 32'h0000_0400, 0, 0, 0, "R3");
    step(STAT, 1'b1, 4'h7, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, 0, "R5");
    rd(STAT, 1'b0, "R5 narrow clear ignored");
    // R3 set / W1C / write 0
    step(STAT, 1'b1, 4'hF, 32'h0, 1'b0, 32'h8000_0001, 0, 0, 0, "R3");
    rd(STAT, 1'b0, "R3 write 0 keeps");
    step(STAT, 1'b1, 4'hF, 32'h0000_0400, 1'b0, 0, 0, 0, 0, "R3");
    rd(STAT, 1'b0, "R3 w1c");
    // R4 set wins over same-cycle clear
    step(STAT, 1'b1, 4'hF, 32'h0000_0800, 1'b0, 32'h0000_0800, 0, 0, 0, "R4");
    rd(STAT, 1'b0, "R4 set wins");
    // R9 queue events ignored in mailbox mode
    step(STAT, 1'b1, 4'hF, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, 0, "R9");
    step(STAT, 1'b0, 4'hF, 0, 1'b0, 0, 1, 1, 1, "R9");
    rd(STAT, 1'b0, "R9 queue events ignored");
    // R8 mode change wipes 7:1 only
    step(STAT, 1'b0, 4'hF, 0, 1'b0, 32'h0100_00FF, 0, 0, 0, "R8");
    step(STAT, 1'b0, 4'hF, 0, 1'b1, 32'h0000_00FE, 0, 0, 0, "R8");
    rd(STAT, 1'b1, "R8 wipe on entry");
    rd(IEN, 1'b1, "R8 enable untouched");
    // R6 / R7 queue mode mapping
    step(STAT, 1'b0, 4'hF, 0, 1'b1, 32'h0000_009E, 1, 0, 1, "R6");
    rd(STAT, 1'b1, "R6 ovf and avail");
    step(STAT, 1'b0, 4'hF, 0, 1'b1, 32'h0000_001E, 0, 1, 0, "R7");
    rd(STAT, 1'b1, "R7 reserved zero");
    step(STAT, 1'b0, 4'hF, 0, 1'b0, 0, 0, 0, 0, "R8");
    rd(STAT, 1'b0, "R8 wipe on exit");
    // R10 irq path
    step(STAT, 1'b1, 4'hF, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, 0, "R10");
    step(IEN, 1'b1, 4'hF, 32'h0000_0020, 1'b0, 0, 0, 0, 0, "R10");
    step(STAT, 1'b0, 4'hF, 0, 1'b0, 32'h0000_0020, 0, 0, 0, "R10");
    rd(STAT, 1'b0, "R10");
    rd(STAT, 1'b0, "R10 irq high");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [31:0] r;
      logic m;
      r = $urandom;
      case (r[1:0])
        2'd0, 2'd1: a = STAT;
        2'd2:       a = IEN;
        default:    a = 8'h2C;
      endcase
      m = ((r[15:8]) == 8'd0) ? ~mode_m : mode_m;
      step(a, r[4:2] == 3'd0, (r[7:5] == 3'd0) ? 4'h5 : 4'hF, $urandom,
           m, $urandom & $urandom & $urandom, r[16], r[17], r[18], "R3/R6");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule